// File: doc/BRIEF.md
# Fan Drive Code Sequencer

This block chooses the 6-bit code that drives a fan supply DAC, and it decides whether the output stage is on. A serial front end hands it a finished command: a code, a boost request bit and a one-cycle commit strobe. The block stores the code. When boost is requested, it first drives full scale for a fixed number of clock cycles, so that a stalled fan can start before its voltage drops to the programmed level.

Digital flags report the analog side: a thermal-shutdown comparator, a hot-die comparator, a cool-down comparator and a current-limit detector. The output stage is off while thermal shutdown is active. When the die recovers, the block starts a boost phase on its own. If the die is still hot when the boost timer expires, full scale is held until the cool-down flag rises. The two fault flags are sent back to the serial side as live flags. They are also captured into a read byte whenever a read address is acknowledged.

The synchronous reset stands for power-on reset and undervoltage lockout. It clears the stored code, the timer, the sequencing state and the status byte.

Top module: `fan_seq_top`

## Requirements
- R1: After reset, `dac_code_o` is 0, `out_en_o` is 1, and `stat_byte_o`, `tsd_flag_o` and `ilim_flag_o` are 0.
- R2: A commit with `cmd_boost`=0 outside thermal shutdown sets `dac_code_o` to `cmd_code` on the clock edge that samples the strobe.
- R3: A commit with `cmd_boost`=1 drives `dac_code_o` to 63 for exactly BOOST_CYCLES cycles, starting at the sampling edge. The stored code then appears.
- R4: A commit with `cmd_boost`=1 during an active boost restarts the full BOOST_CYCLES count. The new code appears only when that count ends.
- R5: A commit with `cmd_boost`=0 during a boost or a hot hold ends full scale at once and applies the new code on the sampling edge.
- R6: While `tsd_i` is 1, one cycle later `out_en_o` is 0, `dac_code_o` is 0 and `tsd_flag_o` is 1. Commits made meanwhile are stored but not applied.
- R7: When `tsd_i` falls, the next edge starts a boost: `out_en_o` returns to 1, 63 is driven for BOOST_CYCLES cycles, and then the most recently stored code is driven.
- R8: If `hot_i` is 1 when the boost count ends, 63 is held until `cool_i` is 1. The stored code appears on the edge that samples `cool_i`.
- R9: `ilim_flag_o` follows `ilim_i` one cycle late. Commits during current limit still take effect.
- R10: On a cycle with `rd_ack` = 1, `stat_byte_o` captures bit 7 = `ilim_i`, bit 6 = `tsd_i`, bits 5..0 = 0. It keeps that value until the next `rd_ack`.
- R11: A reset in the middle of a boost clears everything. No boost or earlier code reappears afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on / undervoltage) |
| cmd_code | input | CODE_W | Committed DAC code |
| cmd_boost | input | 1 | Boost request bit of the committed command |
| cmd_commit | input | 1 | One-cycle strobe: command valid |
| tsd_i | input | 1 | Thermal shutdown active |
| hot_i | input | 1 | Die above the hot threshold |
| cool_i | input | 1 | Die below the cool-down threshold |
| ilim_i | input | 1 | Current limit active |
| rd_ack | input | 1 | Read address acknowledged: capture status |
| dac_code_o | output | CODE_W | Effective code sent to the DAC |
| out_en_o | output | 1 | Output stage enable |
| tsd_flag_o | output | 1 | Registered thermal-shutdown status |
| ilim_flag_o | output | 1 | Registered current-limit status |
| stat_byte_o | output | 8 | Status byte for serial readback |

## Verification
The checker watches five relations on every cycle:
- shutdown always gates the output off one cycle later;
- a disabled output always carries code 0;
- a direct commit lands one cycle later;
- a boost commit gives full scale one cycle later;
- the status byte changes only on an acknowledge, and then carries the faults it sampled.

The cycle counts need the bench's directed scenarios. These are the exact boost length, the restart of that length, the hot hold that waits for the cool-down flag, recovery after shutdown with a code stored during the fault, and a reset in the middle of a boost.

// File: rtl/fan_seq_pkg.sv
package fan_seq_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_BOOST = 2'd1,
    ST_HOLD  = 2'd2,
    ST_OFF   = 2'd3
  } seq_state_t;

  localparam int STAT_W     = 8;
  localparam int STAT_ILIM  = 7;
  localparam int STAT_TSD   = 6;
endpackage

// File: rtl/fan_boost_timer.sv
module fan_boost_timer #(
  parameter int BOOST_CYCLES = 6_250_000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int CNT_W = (BOOST_CYCLES > 2) ? $clog2(BOOST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BOOST_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= RELOAD;
    end else if (run && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = run && !load && (cnt == '0);
endmodule

// File: rtl/fan_seq_ctrl.sv
module fan_seq_ctrl
  import fan_seq_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              cmd_boost,
  input  logic              cmd_commit,
  input  logic              tsd_i,
  input  logic              hot_i,
  input  logic              cool_i,
  input  logic              tmr_done,
  output logic              tmr_load,
  output logic              tmr_run,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              out_en_o
);
  localparam logic [CODE_W-1:0] FULL_CODE = {CODE_W{1'b1}};

  seq_state_t        st, st_nxt;
  logic [CODE_W-1:0] code_q, code_nxt;

  always_comb begin
    st_nxt   = st;
    tmr_load = 1'b0;
    code_nxt = cmd_commit ? cmd_code : code_q;
    if (tsd_i) begin
      st_nxt = ST_OFF;
    end else if (st == ST_OFF) begin
      st_nxt   = ST_BOOST;
      tmr_load = 1'b1;
    end else if (cmd_commit) begin
      if (cmd_boost) begin
        st_nxt   = ST_BOOST;
        tmr_load = 1'b1;
      end else begin
        st_nxt = ST_RUN;
      end
    end else begin
      unique case (st)
        ST_BOOST: if (tmr_done) st_nxt = hot_i ? ST_HOLD : ST_RUN;
        ST_HOLD:  if (cool_i)   st_nxt = ST_RUN;
        default:  st_nxt = st;
      endcase
    end
  end

  assign tmr_run = (st == ST_BOOST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_RUN;
      code_q     <= '0;
      dac_code_o <= '0;
      out_en_o   <= 1'b1;
    end else begin
      st       <= st_nxt;
      code_q   <= code_nxt;
      out_en_o <= (st_nxt != ST_OFF);
      unique case (st_nxt)
        ST_OFF:            dac_code_o <= '0;
        ST_BOOST, ST_HOLD: dac_code_o <= FULL_CODE;
        default:           dac_code_o <= code_nxt;
      endcase
    end
  end
endmodule

// File: rtl/fan_status_reg.sv
module fan_status_reg
  import fan_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tsd_i,
  input  logic              ilim_i,
  input  logic              rd_ack,
  output logic              tsd_flag_o,
  output logic              ilim_flag_o,
  output logic [STAT_W-1:0] stat_byte_o
);
  logic [STAT_W-1:0] snap;

  always_comb begin
    snap            = '0;
    snap[STAT_ILIM] = ilim_i;
    snap[STAT_TSD]  = tsd_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tsd_flag_o  <= 1'b0;
      ilim_flag_o <= 1'b0;
      stat_byte_o <= '0;
    end else begin
      tsd_flag_o  <= tsd_i;
      ilim_flag_o <= ilim_i;
      if (rd_ack) stat_byte_o <= snap;
    end
  end
endmodule

// File: rtl/fan_seq_top.sv
module fan_seq_top
  import fan_seq_pkg::*;
#(
  parameter int CODE_W       = 6,
  parameter int BOOST_CYCLES = 6_250_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              cmd_boost,
  input  logic              cmd_commit,
  input  logic              tsd_i,
  input  logic              hot_i,
  input  logic              cool_i,
  input  logic              ilim_i,
  input  logic              rd_ack,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              out_en_o,
  output logic              tsd_flag_o,
  output logic              ilim_flag_o,
  output logic [7:0]        stat_byte_o
);
  logic tmr_load, tmr_run, tmr_done;

  fan_boost_timer #(.BOOST_CYCLES(BOOST_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .run  (tmr_run),
    .done (tmr_done)
  );

  fan_seq_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cmd_code   (cmd_code),
    .cmd_boost  (cmd_boost),
    .cmd_commit (cmd_commit),
    .tsd_i      (tsd_i),
    .hot_i      (hot_i),
    .cool_i     (cool_i),
    .tmr_done   (tmr_done),
    .tmr_load   (tmr_load),
    .tmr_run    (tmr_run),
    .dac_code_o (dac_code_o),
    .out_en_o   (out_en_o)
  );

  fan_status_reg u_stat (
    .clk         (clk),
    .rst         (rst),
    .tsd_i       (tsd_i),
    .ilim_i      (ilim_i),
    .rd_ack      (rd_ack),
    .tsd_flag_o  (tsd_flag_o),
    .ilim_flag_o (ilim_flag_o),
    .stat_byte_o (stat_byte_o)
  );
endmodule

// File: rtl/fan_seq_checks.sv
module fan_seq_checks #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] cmd_code,
  input logic              cmd_boost,
  input logic              cmd_commit,
  input logic              tsd_i,
  input logic              ilim_i,
  input logic              rd_ack,
  input logic [CODE_W-1:0] dac_code_o,
  input logic              out_en_o,
  input logic [7:0]        stat_byte_o
);
  assert_tsd_off_R6: assert property (@(posedge clk) disable iff (rst)
    tsd_i |=> !out_en_o);

  assert_off_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !out_en_o |-> (dac_code_o == '0));

  assert_direct_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_commit && !cmd_boost && !tsd_i && out_en_o) |=> (dac_code_o == $past(cmd_code)));

  assert_boost_full_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_commit && cmd_boost && !tsd_i) |=> (dac_code_o == {CODE_W{1'b1}}));

  assert_stat_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_ack |=> $stable(stat_byte_o));

  assert_stat_snap_R10: assert property (@(posedge clk) disable iff (rst)
    rd_ack |=> (stat_byte_o == {$past(ilim_i), $past(tsd_i), 6'b0}));
endmodule

bind fan_seq_top fan_seq_checks #(.CODE_W(CODE_W)) u_checks (
  .clk         (clk),
  .rst         (rst),
  .cmd_code    (cmd_code),
  .cmd_boost   (cmd_boost),
  .cmd_commit  (cmd_commit),
  .tsd_i       (tsd_i),
  .ilim_i      (ilim_i),
  .rd_ack      (rd_ack),
  .dac_code_o  (dac_code_o),
  .out_en_o    (out_en_o),
  .stat_byte_o (stat_byte_o)
);

// File: tb/fan_seq_top_bench.sv
module fan_seq_top_bench;
  localparam int CW = 6;
  localparam int N  = 16;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] cmd_code = '0;
  logic cmd_boost = 1'b0, cmd_commit = 1'b0;
  logic tsd_i = 1'b0, hot_i = 1'b0, cool_i = 1'b0, ilim_i = 1'b0, rd_ack = 1'b0;
  logic [CW-1:0] dac_code_o;
  logic out_en_o, tsd_flag_o, ilim_flag_o;
  logic [7:0] stat_byte_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fan_seq_top #(.CODE_W(CW), .BOOST_CYCLES(N)) u_fan_seq_top (
    .clk(clk), .rst(rst), .cmd_code(cmd_code), .cmd_boost(cmd_boost),
    .cmd_commit(cmd_commit), .tsd_i(tsd_i), .hot_i(hot_i), .cool_i(cool_i),
    .ilim_i(ilim_i), .rd_ack(rd_ack), .dac_code_o(dac_code_o),
    .out_en_o(out_en_o), .tsd_flag_o(tsd_flag_o), .ilim_flag_o(ilim_flag_o),
    .stat_byte_o(stat_byte_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic commit(input logic [CW-1:0] c, input logic b);
    cmd_code = c; cmd_boost = b; cmd_commit = 1'b1;
    step(1);
    cmd_commit = 1'b0; cmd_boost = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; step(2); rst = 1'b0; step(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 dac", dac_code_o, 0);
    chk("R1 out_en", out_en_o, 1);
    chk("R1 stat", stat_byte_o, 0);
    chk("R1 flags", {tsd_flag_o, ilim_flag_o}, 0);
  endtask

  task automatic t_direct();
    commit(6'd21, 1'b0);
    chk("R2 direct code", dac_code_o, 21);
    commit(6'd0, 1'b0);
    chk("R2 direct zero", dac_code_o, 0);
  endtask

  task automatic t_boost();
    commit(6'd12, 1'b1);
    chk("R3 first boost cycle", dac_code_o, 63);
    step(N - 1);
    chk("R3 last boost cycle", dac_code_o, 63);
    step(1);
    chk("R3 code after boost", dac_code_o, 12);
  endtask

  task automatic t_restart();
    commit(6'd5, 1'b1);
    step(5);
    commit(6'd9, 1'b1);
    step(N - 1);
    chk("R4 still full after restart", dac_code_o, 63);
    step(1);
    chk("R4 new code after restart", dac_code_o, 9);
  endtask

  task automatic t_cancel();
    commit(6'd30, 1'b1);
    step(3);
    commit(6'd17, 1'b0);
    chk("R5 immediate code", dac_code_o, 17);
    step(N);
    chk("R5 no late boost", dac_code_o, 17);
  endtask

  task automatic t_tsd();
    commit(6'd10, 1'b0);
    tsd_i = 1'b1; step(1);
    chk("R6 out off", out_en_o, 0);
    chk("R6 dac zero", dac_code_o, 0);
    chk("R6 tsd flag", tsd_flag_o, 1);
    commit(6'd20, 1'b0);
    step(2);
    chk("R6 commit not applied", dac_code_o, 0);
    tsd_i = 1'b0; step(1);
    chk("R7 recovery enable", out_en_o, 1);
    chk("R7 recovery full", dac_code_o, 63);
    step(N - 1);
    chk("R7 recovery last full", dac_code_o, 63);
    step(1);
    chk("R7 stored code", dac_code_o, 20);
    chk("R6 flag clear", tsd_flag_o, 0);
  endtask

  task automatic t_hot();
    hot_i = 1'b1;
    commit(6'd7, 1'b1);
    step(N);
    chk("R8 held past timer", dac_code_o, 63);
    step(10);
    chk("R8 still held", dac_code_o, 63);
    hot_i = 1'b0; cool_i = 1'b1; step(1);
    cool_i = 1'b0;
    chk("R8 code after cool", dac_code_o, 7);
  endtask

  task automatic t_status();
    ilim_i = 1'b1; step(1);
    chk("R9 ilim flag", ilim_flag_o, 1);
    commit(6'd40, 1'b0);
    chk("R9 commit in ilim", dac_code_o, 40);
    rd_ack = 1'b1; step(1); rd_ack = 1'b0;
    chk("R10 byte ilim", stat_byte_o, 8'h80);
    ilim_i = 1'b0; tsd_i = 1'b1; step(2);
    chk("R10 byte held", stat_byte_o, 8'h80);
    chk("R9 ilim flag clear", ilim_flag_o, 0);
    rd_ack = 1'b1; step(1); rd_ack = 1'b0;
    chk("R10 byte tsd", stat_byte_o, 8'h40);
    tsd_i = 1'b0; step(N + 2);
    chk("R7 code after status", dac_code_o, 40);
  endtask

  task automatic t_midreset();
    commit(6'd33, 1'b1);
    step(3);
    do_reset();
    chk("R11 dac cleared", dac_code_o, 0);
    chk("R11 stat cleared", stat_byte_o, 0);
    step(N + 2);
    chk("R11 no late code", dac_code_o, 0);
    chk("R11 enabled", out_en_o, 1);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(1);
    t_reset();
    t_direct();
    t_boost();
    t_restart();
    t_cancel();
    t_tsd();
    t_hot();
    t_status();
    t_midreset();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule